// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 SDRAM through its mandatory bring-up after reset. A single-cycle `start` pulse launches a fixed program of fifteen commands. The block presents them one at a time on a valid/ready command port, which a downstream memory controller or PHY front end consumes. Each command carries a command code, a bank index, a full address word with the bank index placed at the correct bit position, and the mode-register value that goes with it.

Between commands the block drops `cmd_valid` for a short fixed gap. After the first no-operation it holds off for a power-up settle time that is counted in clock cycles from the clock frequency parameter. The address position of the bank field is derived from the memory geometry presented at `start`: the column-width code, the row-width code, the address-mapping mode and the data-bus width. Once the final dummy write has been accepted, `init_done` goes high and stays high until reset.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: After `start`, exactly fifteen commands are accepted, with these codes in this order: NOP(0), NOP(0), PRECHARGE_ALL(1), EMRS(3) bank 2, EMRS(3) bank 3, EMRS(3) bank 1, MRS(2), PRECHARGE_ALL(1), REFRESH(4), REFRESH(4), MRS(2), EMRS(3) bank 1, EMRS(3) bank 1, NORMAL(5), WRITE(6).
- R2: After the first NOP is accepted, `cmd_valid` stays low for exactly WAIT_CYC = (CLK_FREQ_HZ / 1,000,000) × WAIT_US cycles before the second NOP is offered.
- R3: While `cmd_valid` is high and `cmd_ready` is low, the command and all of its fields stay unchanged. After every accepted command other than the first and the last, `cmd_valid` stays low for exactly CMD_GAP cycles.
- R4: `cmd_mrval` works as follows. The first MRS has bit DLL_RST_BIT (8) set and the second MRS has it clear, with all other bits taken from MRS_BASE. Every bank-1 EMRS has bit 0 clear. The three bank-1 EMRS commands carry the OCD field, bits [9:7], as 000, 111 and 000, with all other bits taken from EMRS1_BASE. The bank-2 EMRS carries EMRS2_VAL. The bank-3 EMRS carries zero. All other commands carry zero.
- R5: The bank offset is computed as column code + 9. When `cfg_seq_map` is 1, the row code + 11 is added to it. Finally 1 is added when `cfg_narrow` is 1, or 2 when it is 0. `cmd_bank` is the target index (1, 2 or 3) for an EMRS and 0 for all other commands. `cmd_addr` equals `cmd_bank` shifted left by that offset.
- R6: `init_done` rises in the cycle after the WRITE is accepted. It stays high until reset, and `cmd_valid` is never high while it is set.
- R7: A `start` pulse is ignored while a sequence is running and after `init_done` has been set.
- R8: During and after reset, `cmd_valid` and `init_done` are low and all command fields are zero.
- R9: The configuration inputs are captured in the cycle `start` is accepted. Changing them later has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when idle |
| cfg_col | input | CFG_W | Column-width code |
| cfg_row | input | CFG_W | Row-width code |
| cfg_seq_map | input | 1 | 1 = sequential mapping, 0 = interleaved |
| cfg_narrow | input | 1 | 1 = narrow data bus, 0 = full width |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high with valid |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | 2 | Mode-register target bank |
| cmd_addr | output | ADDR_W | Address word with bank at computed offset |
| cmd_mrval | output | MR_W | Mode-register value |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions assume that `cmd_ready` may be low for any number of cycles, that `start` and the configuration inputs may change at any time, and that nothing other than reset clears a completed run. The stimulus keeps these inputs changing only between clock edges. It covers three geometries: interleaved full-width, sequential narrow, and sequential full-width. It runs with `cmd_ready` both tied high and randomly stalled. In the middle of a run it pulses `start` again and flips the configuration inputs, and it does the same after completion.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

   localparam int STEP_W    = 4;
   localparam int NUM_STEPS = 15;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_PALL = 3'd1,
      CMD_MRS  = 3'd2,
      CMD_EMRS = 3'd3,
      CMD_REF  = 3'd4,
      CMD_NORM = 3'd5,
      CMD_WR   = 3'd6
   } ddr2_cmd_e;

   typedef struct packed {
      ddr2_cmd_e  cmd;
      logic [1:0] bank;
      logic       dll_rst;
      logic       ocd_dflt;
   } step_t;

   // Program of the bring-up; the order is the behaviour.
   function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
      step_t s;
      s = '{cmd: CMD_NOP, bank: 2'd0, dll_rst: 1'b0, ocd_dflt: 1'b0};
      case (idx)
         4'd0, 4'd1:  s.cmd = CMD_NOP;
         4'd2, 4'd7:  s.cmd = CMD_PALL;
         4'd3:        begin s.cmd = CMD_EMRS; s.bank = 2'd2; end
         4'd4:        begin s.cmd = CMD_EMRS; s.bank = 2'd3; end
         4'd5:        begin s.cmd = CMD_EMRS; s.bank = 2'd1; end
         4'd6:        begin s.cmd = CMD_MRS;  s.dll_rst = 1'b1; end
         4'd8, 4'd9:  s.cmd = CMD_REF;
         4'd10:       s.cmd = CMD_MRS;
         4'd11:       begin s.cmd = CMD_EMRS; s.bank = 2'd1; s.ocd_dflt = 1'b1; end
         4'd12:       begin s.cmd = CMD_EMRS; s.bank = 2'd1; end
         4'd13:       s.cmd = CMD_NORM;
         4'd14:       s.cmd = CMD_WR;
         default:     s.cmd = CMD_NOP;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ddr2_bank_offset.sv
`timescale 1ns/1ps
module ddr2_bank_offset #(
   parameter int CFG_W = 2,
   parameter int OFF_W = 5
) (
   input  logic [CFG_W-1:0] col_code,
   input  logic [CFG_W-1:0] row_code,
   input  logic             seq_map,
   input  logic             narrow,
   output logic [OFF_W-1:0] bank_off
);

   localparam int MAX_OFF = 2 * ((1 << CFG_W) - 1) + 9 + 11 + 2;

   generate
      if (MAX_OFF >= (1 << OFF_W)) begin : g_bad_off_w
         $error("OFF_W too narrow for the largest bank offset");
      end
   endgenerate

   always_comb begin
      int acc;
      acc = int'(col_code) + 9;
      if (seq_map) acc = acc + int'(row_code) + 11;
      acc = acc + (narrow ? 1 : 2);
      bank_off = OFF_W'(acc);
   end

endmodule

// File: rtl/ddr2_step_decode.sv
`timescale 1ns/1ps
module ddr2_step_decode
   import ddr2_init_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter int              MR_W        = 14,
   parameter int              OFF_W       = 5,
   parameter int              DLL_RST_BIT = 8,
   parameter int              OCD_LSB     = 7,
   parameter int              OCD_W       = 3,
   parameter logic [MR_W-1:0] MRS_BASE    = '0,
   parameter logic [MR_W-1:0] EMRS1_BASE  = '0,
   parameter logic [MR_W-1:0] EMRS2_VAL   = '0
) (
   input  logic [STEP_W-1:0] step,
   input  logic [OFF_W-1:0]  bank_off,
   output ddr2_cmd_e         cmd,
   output logic [1:0]        bank,
   output logic [ADDR_W-1:0] addr,
   output logic [MR_W-1:0]   mrval
);

   generate
      if (DLL_RST_BIT >= MR_W || OCD_LSB + OCD_W > MR_W) begin : g_bad_field
         $error("mode-register fields exceed MR_W");
      end
   endgenerate

   step_t s;

   always_comb begin
      s    = step_lookup(step);
      cmd  = s.cmd;
      bank = s.bank;
      addr = ADDR_W'(s.bank) << bank_off;
   end

   always_comb begin
      mrval = '0;
      if (s.cmd == CMD_MRS) begin
         mrval              = MRS_BASE;
         mrval[DLL_RST_BIT] = s.dll_rst;
      end else if (s.cmd == CMD_EMRS) begin
         case (s.bank)
            2'd1: begin
               mrval                    = EMRS1_BASE;
               mrval[0]                 = 1'b0;
               mrval[OCD_LSB +: OCD_W]  = {OCD_W{s.ocd_dflt}};
            end
            2'd2:    mrval = EMRS2_VAL;
            default: mrval = '0;
         endcase
      end
   end

endmodule

// File: rtl/ddr2_delay_timer.sv
`timescale 1ns/1ps
module ddr2_delay_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             busy,
   output logic             last
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= len;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign last = (cnt == CNT_W'(1));

   // R2
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> len != '0);

   // R3
   reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

endmodule

// File: rtl/ddr2_pwrup_seq.sv
`timescale 1ns/1ps
module ddr2_pwrup_seq
   import ddr2_init_pkg::*;
#(
   parameter int              CLK_FREQ_HZ = 200_000_000,
   parameter int              WAIT_US     = 200,
   parameter int              CMD_GAP     = 4,
   parameter int              ADDR_W      = 32,
   parameter int              MR_W        = 14,
   parameter int              CFG_W       = 2,
   parameter int              DLL_RST_BIT = 8,
   parameter int              OCD_LSB     = 7,
   parameter int              OCD_W       = 3,
   parameter logic [MR_W-1:0] MRS_BASE    = 14'h0052,
   parameter logic [MR_W-1:0] EMRS1_BASE  = 14'h0004,
   parameter logic [MR_W-1:0] EMRS2_VAL   = 14'h0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CFG_W-1:0]  cfg_col,
   input  logic [CFG_W-1:0]  cfg_row,
   input  logic              cfg_seq_map,
   input  logic              cfg_narrow,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [2:0]        cmd_code,
   output logic [1:0]        cmd_bank,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [MR_W-1:0]   cmd_mrval,
   output logic              init_done
);

   localparam longint WAIT_CYC = (longint'(CLK_FREQ_HZ) / 64'd1_000_000) * longint'(WAIT_US);
   localparam int     CNT_W    = $clog2(WAIT_CYC + 1);
   localparam int     MAX_OFF  = 2 * ((1 << CFG_W) - 1) + 9 + 11 + 2;
   localparam int     OFF_W    = $clog2(MAX_OFF + 1);

   generate
      if (WAIT_CYC < 1)                 begin : g_bad_wait  $error("settle time is zero cycles"); end
      if (CMD_GAP < 1)                  begin : g_bad_gap   $error("CMD_GAP must be at least 1"); end
      if (longint'(CMD_GAP) > WAIT_CYC) begin : g_gap_wide  $error("CMD_GAP exceeds the settle time"); end
      if (ADDR_W < MAX_OFF + 2)         begin : g_bad_addr  $error("ADDR_W cannot hold the bank field"); end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} seq_st_e;

   seq_st_e           state;
   logic [STEP_W-1:0] step;
   logic [CFG_W-1:0]  col_q, row_q;
   logic              seq_q, narrow_q;
   logic [OFF_W-1:0]  bank_off;
   logic              accept, tmr_load, tmr_busy, tmr_last;
   logic [CNT_W-1:0]  tmr_len;
   ddr2_cmd_e         dec_cmd;
   logic [1:0]        dec_bank;
   logic [ADDR_W-1:0] dec_addr;
   logic [MR_W-1:0]   dec_mrval;

   ddr2_bank_offset #(.CFG_W(CFG_W), .OFF_W(OFF_W)) i_off (
      .col_code (col_q),
      .row_code (row_q),
      .seq_map  (seq_q),
      .narrow   (narrow_q),
      .bank_off (bank_off)
   );

   ddr2_step_decode #(
      .ADDR_W(ADDR_W), .MR_W(MR_W), .OFF_W(OFF_W), .DLL_RST_BIT(DLL_RST_BIT),
      .OCD_LSB(OCD_LSB), .OCD_W(OCD_W), .MRS_BASE(MRS_BASE),
      .EMRS1_BASE(EMRS1_BASE), .EMRS2_VAL(EMRS2_VAL)
   ) i_dec (
      .step     (step),
      .bank_off (bank_off),
      .cmd      (dec_cmd),
      .bank     (dec_bank),
      .addr     (dec_addr),
      .mrval    (dec_mrval)
   );

   ddr2_delay_timer #(.CNT_W(CNT_W)) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (tmr_len),
      .busy  (tmr_busy),
      .last  (tmr_last)
   );

   assign accept   = (state == ST_ISSUE) && cmd_ready;
   assign tmr_load = accept && (step != LAST_STEP);
   assign tmr_len  = (step == '0) ? CNT_W'(WAIT_CYC) : CNT_W'(CMD_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step     <= '0;
         col_q    <= '0;
         row_q    <= '0;
         seq_q    <= 1'b0;
         narrow_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state    <= ST_ISSUE;
               step     <= '0;
               col_q    <= cfg_col;
               row_q    <= cfg_row;
               seq_q    <= cfg_seq_map;
               narrow_q <= cfg_narrow;
            end
            ST_ISSUE: if (accept) begin
               state <= (step == LAST_STEP) ? ST_DONE : ST_WAIT;
            end
            ST_WAIT: if (tmr_last) begin
               state <= ST_ISSUE;
               step  <= step + 1'b1;
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign cmd_valid = (state == ST_ISSUE);
   assign init_done = (state == ST_DONE);
   assign cmd_code  = cmd_valid ? 3'(dec_cmd) : 3'(CMD_NOP);
   assign cmd_bank  = cmd_valid ? dec_bank  : '0;
   assign cmd_addr  = cmd_valid ? dec_addr  : '0;
   assign cmd_mrval = cmd_valid ? dec_mrval : '0;

   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr)
                                  && $stable(cmd_mrval) && $stable(cmd_bank));

   // R2
   wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WAIT |-> tmr_busy);

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> !cmd_valid);

   // R5
   emrs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == 3'(CMD_EMRS) |-> cmd_bank != 2'd0);

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != ST_IDLE && start |=> state != ST_IDLE);

   // R8
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> !cmd_valid && !init_done);

endmodule

// File: tb/test_ddr2_pwrup_seq.sv
`timescale 1ns/1ps
module test_ddr2_pwrup_seq;

   localparam int     FREQ   = 200_000_000;
   localparam int     WUS    = 20;
   localparam int     GAP    = 4;
   localparam int     AW     = 32;
   localparam int     MW     = 14;
   localparam longint WCYC   = (longint'(FREQ) / 1_000_000) * WUS;
   localparam int     MRSB   = 'h0052;
   localparam int     EM1B   = 'h0004;
   localparam int     EM2V   = 'h0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    cfg_col = '0, cfg_row = '0;
   logic          cfg_seq_map = 1'b0, cfg_narrow = 1'b0;
   logic          cmd_valid, cmd_ready = 1'b0;
   logic [2:0]    cmd_code;
   logic [1:0]    cmd_bank;
   logic [AW-1:0] cmd_addr;
   logic [MW-1:0] cmd_mrval;
   logic          init_done;

   int total = 0, bad = 0, cyc = 0;
   bit stall_en = 1'b0;

   ddr2_pwrup_seq #(.CLK_FREQ_HZ(FREQ), .WAIT_US(WUS), .CMD_GAP(GAP)) i_ddr2_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_col(cfg_col), .cfg_row(cfg_row),
      .cfg_seq_map(cfg_seq_map), .cfg_narrow(cfg_narrow), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .cmd_mrval(cmd_mrval), .init_done(init_done)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int e_code[$], e_bank[$], e_mr[$];
   int m_state = 0;   // 0 idle, 1 offering, 2 silent, 3 done
   int m_idx = 0, m_cnt = 0, m_off = 0;

   task automatic push(input int c, input int b, input int mr);
      e_code.push_back(c); e_bank.push_back(b); e_mr.push_back(mr);
   endtask

   task automatic build_program();
      int em1;
      em1 = EM1B & ~1 & ~(7 << 7);
      e_code.delete(); e_bank.delete(); e_mr.delete();
      push(0, 0, 0);            push(0, 0, 0);            push(1, 0, 0);
      push(3, 2, EM2V);         push(3, 3, 0);            push(3, 1, em1);
      push(2, 0, MRSB | (1 << 8));                        push(1, 0, 0);
      push(4, 0, 0);            push(4, 0, 0);
      push(2, 0, MRSB & ~(1 << 8));
      push(3, 1, em1 | (7 << 7));                         push(3, 1, em1);
      push(5, 0, 0);            push(6, 0, 0);
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_idx = 0; m_cnt = 0;
      end else begin
         case (m_state)
            0: if (start) begin
               build_program();
               m_off = int'(cfg_col) + 9 + (cfg_seq_map ? int'(cfg_row) + 11 : 0)
                       + (cfg_narrow ? 1 : 2);
               m_state = 1; m_idx = 0;
            end
            1: if (cmd_ready) begin
               if (m_idx == 14) m_state = 3;
               else begin m_cnt = (m_idx == 0) ? int'(WCYC) : GAP; m_state = 2; end
            end
            2: begin
               m_cnt--;
               if (m_cnt == 0) begin m_idx++; m_state = 1; end
            end
            default: m_state = 3;
         endcase
      end
   end

   // ---------------- per-cycle comparison, ready drive, gap timing ----------------
   int  acc_cnt = 0, gap_len = 0;
   bit  gap_on = 1'b0, gap_first = 1'b0;

   always @(negedge clk) begin
      bit nr;
      if (rst_n) begin
         chk(cmd_valid == (m_state == 1), "R3", "cmd_valid", cmd_valid, m_state == 1);
         chk(init_done == (m_state == 3), "R6", "init_done", init_done, m_state == 3);
         if (cmd_valid && m_state == 1) begin
            chk(cmd_code == e_code[m_idx], "R1", "cmd_code", cmd_code, e_code[m_idx]);
            chk(cmd_bank == e_bank[m_idx], "R5", "cmd_bank", cmd_bank, e_bank[m_idx]);
            chk(cmd_addr == (AW'(e_bank[m_idx]) << m_off), "R5/R9", "cmd_addr",
                cmd_addr, AW'(e_bank[m_idx]) << m_off);
            chk(cmd_mrval == MW'(e_mr[m_idx]), "R4", "cmd_mrval", cmd_mrval, e_mr[m_idx]);
         end
         if (cmd_valid) begin
            if (gap_on) begin
               if (gap_first)
                  chk(gap_len == WCYC, "R2", "settle gap", gap_len, WCYC);
               else
                  chk(gap_len == GAP, "R3", "command gap", gap_len, GAP);
               gap_on = 1'b0;
            end
         end else if (gap_on) gap_len++;
      end
      nr = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      cmd_ready = nr;
      if (rst_n && cmd_valid && nr) begin
         if (acc_cnt < 14) begin
            gap_on = 1'b1; gap_len = 0; gap_first = (acc_cnt == 0);
         end
         acc_cnt++;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; start = 1'b0;
      repeat (3) @(negedge clk);
      // R8
      chk(!cmd_valid && !init_done, "R8", "flags in reset", {cmd_valid, init_done}, 0);
      chk(cmd_code == 0 && cmd_bank == 0 && cmd_addr == 0 && cmd_mrval == 0, "R8",
          "fields in reset", cmd_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cmd_valid && !init_done, "R8", "idle after reset", {cmd_valid, init_done}, 0);
   endtask

   task automatic run(input logic [1:0] c, input logic [1:0] r, input bit s, input bit n,
                      input bit stall, input bit disturb);
      cfg_col = c; cfg_row = r; cfg_seq_map = s; cfg_narrow = n; stall_en = stall;
      acc_cnt = 0; gap_on = 1'b0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      if (disturb) begin
         // R9: geometry changes after capture; R7: extra start while running
         @(negedge clk); cfg_col = ~c; cfg_row = ~r; cfg_seq_map = ~s; cfg_narrow = ~n;
         repeat (100) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
         while (acc_cnt < 8) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      while (!init_done) @(negedge clk);
      // R1
      chk(acc_cnt == 15, "R1", "accepted commands", acc_cnt, 15);
      // R7: start after completion is ignored
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk(!cmd_valid && init_done, "R7", "restart after done", {cmd_valid, init_done}, 1);
      chk(acc_cnt == 15, "R7", "no extra command", acc_cnt, 15);
   endtask

   initial begin
      do_reset();
      run(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);   // interleaved, full width: offset 12
      do_reset();
      run(2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1);   // sequential, narrow: offset 27
      do_reset();
      run(2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);   // sequential, full width: offset 22
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule